// File: doc/BRIEF.md
# No-Stretch I2C Slave Byte Holding Buffer

This block holds one received byte and one byte to transmit for an I2C slave that is never allowed to hold SCL low. It sits between a bit-level slave shifter and a register-access interface. The shifter sends it strobes: a received byte is complete, the next transmit byte is needed, or a STOP has been seen. The register side reads the receive holding register, writes the transmit holding register, and clears the error flag.

The slave cannot pause the bus. When a byte arrives before the previous one has been read, the new byte is dropped and answered with a NACK. When a transmit byte is needed and none has been written, a fill value (all ones, 0xFF for 8-bit data) goes out in its place. Both events set one sticky overrun flag. The interrupt line is raised from that flag when error interrupts are enabled.

Error checking is active only when the slave role and the no-stretch option are both configured. Outside that mode the buffer never raises the flag.

Top module: `nsb_slave_buf`

## Requirements
- R1: After reset the receive and transmit holding registers are empty, the overrun flag and irq are 0, and the transmit byte output equals FILL_BYTE.
- R2: A received byte strobed while the receive register is empty is stored, host_rx_full becomes 1, and one cycle after the strobe sh_rx_resp_valid is 1 with sh_rx_nack = 0 (ACK).
- R3: When checking is active, a received byte strobed while the receive register is full and not being read is dropped. The stored byte is kept, sh_rx_nack is 1 in the response cycle, and the overrun flag is set.
- R4: A host_rx_rd pulse clears host_rx_full. host_rx_data keeps showing the last stored byte.
- R5: A host_tx_wr pulse loads the transmit register and sets host_tx_full. A sh_tx_req while it is full puts that byte on sh_tx_byte in the next cycle and clears host_tx_full. Outside the first byte after a STOP, no flag is set.
- R6: A sh_tx_req while the transmit register is empty puts FILL_BYTE on sh_tx_byte in the next cycle. When checking is active, it also sets the overrun flag.
- R7: For the first sh_tx_req after a sh_stop_seen strobe, the transmit register contents are sent if it is full, and FILL_BYTE otherwise. When checking is active, the overrun flag is set in both cases. Later requests follow R5 and R6.
- R8: Checking is active only when cfg_slave and cfg_nostretch are both 1. Otherwise the flag is never set, a byte received while full overwrites the stored byte and is ACKed, and an empty transmit register still yields FILL_BYTE.
- R9: The overrun flag is sticky. A host_clr_wr pulse whose data has bit OVR_CLR_BIT set clears it. The same pulse with that bit 0 leaves it set. A new error event in the same cycle as a clear leaves it set.
- R10: irq equals cfg_err_ie AND the overrun flag, in the same cycle (IRQ_REG = 0).
- R11: A host read in the same cycle as a receive strobe lets the new byte be accepted with ACK. A host write in the same cycle as a transmit request does not serve that request: it is treated as empty, and the written byte stays held for the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_slave | input | 1 | Block operates as a slave |
| cfg_nostretch | input | 1 | Clock stretching is forbidden |
| cfg_err_ie | input | 1 | Error interrupt enable |
| sh_rx_valid | input | 1 | Shifter strobe: a received byte is complete |
| sh_rx_byte | input | DATA_W | Received byte |
| sh_rx_resp_valid | output | 1 | Response for the last strobed byte is valid |
| sh_rx_nack | output | 1 | 1 = answer NACK, 0 = answer ACK |
| sh_tx_req | input | 1 | Shifter strobe: next transmit byte needed |
| sh_stop_seen | input | 1 | Shifter strobe: STOP condition detected |
| sh_tx_byte | output | DATA_W | Byte the shifter sends |
| host_rx_rd | input | 1 | Host read of the receive register |
| host_rx_data | output | DATA_W | Receive register contents |
| host_rx_full | output | 1 | Receive register holds an unread byte |
| host_tx_wr | input | 1 | Host write of the transmit register |
| host_tx_wdata | input | DATA_W | Data written to the transmit register |
| host_tx_full | output | 1 | Transmit register holds an unsent byte |
| host_clr_wr | input | 1 | Write strobe of the clear register |
| host_clr_wdata | input | CLR_W | Clear register write data, write one to clear |
| ovr_flag | output | 1 | Sticky overrun/underrun flag |
| irq | output | 1 | Error interrupt request |

## Verification
The bench uses 8-bit data with the all-ones fill value, so the substituted byte is 0xFF and can be told apart from written bytes. It moves the clear bit to position 2 of an 8-bit clear register. A write with only bit 0 set then shows that only the configured bit clears the flag. It also drives same-cycle collisions: a read with a receive, a write with a request, and a clear with a new error. Each of these is handled by a different priority rule.

// File: rtl/nsb_pkg.sv
package nsb_pkg;
   // Source chosen for the byte the shifter will send next
   typedef enum logic {
      PICK_HELD = 1'b0,
      PICK_FILL = 1'b1
   } tx_pick_e;

   // Error events reported by the two holding paths in one cycle
   typedef struct packed {
      logic rx_drop;
      logic tx_short;
   } err_evt_t;
endpackage

// File: rtl/nsb_rx_hold.sv
module nsb_rx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              checked,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_in,
   input  logic              host_rd,
   output logic [DATA_W-1:0] data_q,
   output logic              full_q,
   output logic              resp_vld_q,
   output logic              resp_nack_q,
   output logic              drop_evt
);
   logic full_eff;
   logic accept;

   // A read in the same cycle frees the slot before the new byte lands
   assign full_eff = full_q & ~host_rd;
   assign accept   = byte_vld & (~full_eff | ~checked);
   assign drop_evt = byte_vld & full_eff & checked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q      <= '0;
         full_q      <= 1'b0;
         resp_vld_q  <= 1'b0;
         resp_nack_q <= 1'b0;
      end else begin
         resp_vld_q  <= byte_vld;
         resp_nack_q <= drop_evt;
         if (accept) begin
            data_q <= byte_in;
            full_q <= 1'b1;
         end else if (host_rd) begin
            full_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/nsb_tx_hold.sv
module nsb_tx_hold
   import nsb_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter logic [DATA_W-1:0] FILL_BYTE = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              checked,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              req,
   input  logic              stop_seen,
   output logic              full_q,
   output logic [DATA_W-1:0] tx_q,
   output logic              short_evt
);
   logic [DATA_W-1:0] hold_q;
   logic              stop_pend_q;
   tx_pick_e          pick;

   // Decision uses the state before any same-cycle host write
   assign pick      = full_q ? PICK_HELD : PICK_FILL;
   assign short_evt = req & checked & (stop_pend_q | (pick == PICK_FILL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q      <= '0;
         full_q      <= 1'b0;
         tx_q        <= FILL_BYTE;
         stop_pend_q <= 1'b0;
      end else begin
         if (req) begin
            tx_q <= (pick == PICK_HELD) ? hold_q : FILL_BYTE;
         end
         if (host_wr) begin
            hold_q <= host_wdata;
            full_q <= 1'b1;
         end else if (req) begin
            full_q <= 1'b0;
         end
         if (stop_seen) begin
            stop_pend_q <= 1'b1;
         end else if (req) begin
            stop_pend_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/nsb_err_flags.sv
module nsb_err_flags
   import nsb_pkg::*;
#(
   parameter int CLR_W       = 8,
   parameter int OVR_CLR_BIT = 0,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  err_evt_t         evt,
   input  logic             clr_wr,
   input  logic [CLR_W-1:0] clr_wdata,
   input  logic             irq_en,
   output logic             ovr_q,
   output logic             irq
);
   logic any_evt;
   logic clr_hit;

   assign any_evt = evt.rx_drop | evt.tx_short;
   assign clr_hit = clr_wr & clr_wdata[OVR_CLR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q <= 1'b0;
      end else if (any_evt) begin
         ovr_q <= 1'b1;
      end else if (clr_hit) begin
         ovr_q <= 1'b0;
      end
   end

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_en & ovr_q;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_en & ovr_q;
      end
   endgenerate
endmodule

// File: rtl/nsb_slave_buf.sv
module nsb_slave_buf
   import nsb_pkg::*;
#(
   parameter int                DATA_W      = 8,
   parameter logic [DATA_W-1:0] FILL_BYTE   = '1,
   parameter int                CLR_W       = 8,
   parameter int                OVR_CLR_BIT = 0,
   parameter bit                IRQ_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_slave,
   input  logic              cfg_nostretch,
   input  logic              cfg_err_ie,
   input  logic              sh_rx_valid,
   input  logic [DATA_W-1:0] sh_rx_byte,
   output logic              sh_rx_resp_valid,
   output logic              sh_rx_nack,
   input  logic              sh_tx_req,
   input  logic              sh_stop_seen,
   output logic [DATA_W-1:0] sh_tx_byte,
   input  logic              host_rx_rd,
   output logic [DATA_W-1:0] host_rx_data,
   output logic              host_rx_full,
   input  logic              host_tx_wr,
   input  logic [DATA_W-1:0] host_tx_wdata,
   output logic              host_tx_full,
   input  logic              host_clr_wr,
   input  logic [CLR_W-1:0]  host_clr_wdata,
   output logic              ovr_flag,
   output logic              irq
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("nsb_slave_buf: DATA_W must be at least 1");
      end
      if (OVR_CLR_BIT < 0 || OVR_CLR_BIT >= CLR_W) begin : g_bad_clr_bit
         $error("nsb_slave_buf: OVR_CLR_BIT outside the clear register");
      end
   endgenerate

   logic     checked;
   err_evt_t evt;

   assign checked = cfg_slave & cfg_nostretch;

   nsb_rx_hold #(.DATA_W(DATA_W)) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .checked     (checked),
      .byte_vld    (sh_rx_valid),
      .byte_in     (sh_rx_byte),
      .host_rd     (host_rx_rd),
      .data_q      (host_rx_data),
      .full_q      (host_rx_full),
      .resp_vld_q  (sh_rx_resp_valid),
      .resp_nack_q (sh_rx_nack),
      .drop_evt    (evt.rx_drop)
   );

   nsb_tx_hold #(.DATA_W(DATA_W), .FILL_BYTE(FILL_BYTE)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .checked    (checked),
      .host_wr    (host_tx_wr),
      .host_wdata (host_tx_wdata),
      .req        (sh_tx_req),
      .stop_seen  (sh_stop_seen),
      .full_q     (host_tx_full),
      .tx_q       (sh_tx_byte),
      .short_evt  (evt.tx_short)
   );

   nsb_err_flags #(
      .CLR_W       (CLR_W),
      .OVR_CLR_BIT (OVR_CLR_BIT),
      .IRQ_REG     (IRQ_REG)
   ) u_err (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (evt),
      .clr_wr    (host_clr_wr),
      .clr_wdata (host_clr_wdata),
      .irq_en    (cfg_err_ie),
      .ovr_q     (ovr_flag),
      .irq       (irq)
   );
endmodule

// File: rtl/nsb_slave_buf_chk.sv
module nsb_slave_buf_chk #(
   parameter int                DATA_W      = 8,
   parameter logic [DATA_W-1:0] FILL_BYTE   = '1,
   parameter int                CLR_W       = 8,
   parameter int                OVR_CLR_BIT = 0,
   parameter bit                IRQ_REG     = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_slave,
   input logic              cfg_nostretch,
   input logic              sh_rx_valid,
   input logic [DATA_W-1:0] sh_rx_byte,
   input logic              sh_rx_nack,
   input logic              sh_tx_req,
   input logic [DATA_W-1:0] sh_tx_byte,
   input logic              host_rx_rd,
   input logic [DATA_W-1:0] host_rx_data,
   input logic              host_rx_full,
   input logic              host_tx_wr,
   input logic              host_tx_full,
   input logic              host_clr_wr,
   input logic [CLR_W-1:0]  host_clr_wdata,
   input logic              ovr_flag,
   input logic              irq
);
   logic chk_on;
   assign chk_on = cfg_slave & cfg_nostretch;

   p_ack_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sh_rx_valid && (!host_rx_full || host_rx_rd || !chk_on)
      |=> !sh_rx_nack && host_rx_full && host_rx_data == $past(sh_rx_byte));

   p_drop_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sh_rx_valid && host_rx_full && !host_rx_rd && chk_on
      |=> sh_rx_nack && ovr_flag && $stable(host_rx_data));

   p_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sh_tx_req && host_tx_full && !host_tx_wr |=> !host_tx_full);

   p_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sh_tx_req && !host_tx_full |=> sh_tx_byte == FILL_BYTE);

   p_short_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sh_tx_req && !host_tx_full && chk_on |=> ovr_flag);

   p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_on && !ovr_flag |=> !ovr_flag);

   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      host_clr_wr && host_clr_wdata[OVR_CLR_BIT] && !sh_rx_valid && !sh_tx_req
      |=> !ovr_flag);

   p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (IRQ_REG == 1'b0) && irq |-> ovr_flag);
endmodule

bind nsb_slave_buf nsb_slave_buf_chk #(
   .DATA_W      (DATA_W),
   .FILL_BYTE   (FILL_BYTE),
   .CLR_W       (CLR_W),
   .OVR_CLR_BIT (OVR_CLR_BIT),
   .IRQ_REG     (IRQ_REG)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_slave      (cfg_slave),
   .cfg_nostretch  (cfg_nostretch),
   .sh_rx_valid    (sh_rx_valid),
   .sh_rx_byte     (sh_rx_byte),
   .sh_rx_nack     (sh_rx_nack),
   .sh_tx_req      (sh_tx_req),
   .sh_tx_byte     (sh_tx_byte),
   .host_rx_rd     (host_rx_rd),
   .host_rx_data   (host_rx_data),
   .host_rx_full   (host_rx_full),
   .host_tx_wr     (host_tx_wr),
   .host_tx_full   (host_tx_full),
   .host_clr_wr    (host_clr_wr),
   .host_clr_wdata (host_clr_wdata),
   .ovr_flag       (ovr_flag),
   .irq            (irq)
);

// File: tb/nsb_slave_buf_bench.sv
module nsb_slave_buf_bench;
   localparam int DW  = 8;
   localparam int CW  = 8;
   localparam int CLB = 2;
   localparam logic [DW-1:0] FILL = 8'hFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_slave = 1'b1, cfg_nostretch = 1'b1, cfg_err_ie = 1'b0;
   logic          sh_rx_valid = 1'b0;
   logic [DW-1:0] sh_rx_byte = '0;
   logic          sh_rx_resp_valid, sh_rx_nack;
   logic          sh_tx_req = 1'b0, sh_stop_seen = 1'b0;
   logic [DW-1:0] sh_tx_byte;
   logic          host_rx_rd = 1'b0;
   logic [DW-1:0] host_rx_data;
   logic          host_rx_full;
   logic          host_tx_wr = 1'b0;
   logic [DW-1:0] host_tx_wdata = '0;
   logic          host_tx_full;
   logic          host_clr_wr = 1'b0;
   logic [CW-1:0] host_clr_wdata = '0;
   logic          ovr_flag, irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   nsb_slave_buf #(
      .DATA_W(DW), .FILL_BYTE(FILL), .CLR_W(CW), .OVR_CLR_BIT(CLB), .IRQ_REG(1'b0)
   ) u_nsb_slave_buf (.*);

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // one-cycle strobes; drive at negedge, results visible at the next negedge
   task automatic rx_push(input logic [DW-1:0] b, input logic rd);
      @(negedge clk);
      sh_rx_valid = 1'b1; sh_rx_byte = b; host_rx_rd = rd;
      @(negedge clk);
      sh_rx_valid = 1'b0; host_rx_rd = 1'b0;
   endtask

   task automatic host_read();
      @(negedge clk); host_rx_rd = 1'b1;
      @(negedge clk); host_rx_rd = 1'b0;
   endtask

   task automatic host_write(input logic [DW-1:0] b);
      @(negedge clk); host_tx_wr = 1'b1; host_tx_wdata = b;
      @(negedge clk); host_tx_wr = 1'b0;
   endtask

   task automatic tx_request();
      @(negedge clk); sh_tx_req = 1'b1;
      @(negedge clk); sh_tx_req = 1'b0;
   endtask

   task automatic stop_strobe();
      @(negedge clk); sh_stop_seen = 1'b1;
      @(negedge clk); sh_stop_seen = 1'b0;
   endtask

   task automatic clear_write(input logic [CW-1:0] v);
      @(negedge clk); host_clr_wr = 1'b1; host_clr_wdata = v;
      @(negedge clk); host_clr_wr = 1'b0; host_clr_wdata = '0;
   endtask

   task automatic t_reset();
      check("R1", "rx_full", host_rx_full, 0);
      check("R1", "tx_full", host_tx_full, 0);
      check("R1", "ovr", ovr_flag, 0);
      check("R1", "irq", irq, 0);
      check("R1", "tx_byte", sh_tx_byte, FILL);
   endtask

   task automatic t_rx_basic();
      rx_push(8'hA5, 1'b0);
      check("R2", "resp_valid", sh_rx_resp_valid, 1);
      check("R2", "nack", sh_rx_nack, 0);
      check("R2", "rx_full", host_rx_full, 1);
      check("R2", "rx_data", host_rx_data, 8'hA5);
      check("R2", "ovr", ovr_flag, 0);
   endtask

   task automatic t_rx_overrun();
      rx_push(8'h3C, 1'b0);
      check("R3", "nack", sh_rx_nack, 1);
      check("R3", "rx_data kept", host_rx_data, 8'hA5);
      check("R3", "ovr", ovr_flag, 1);
      check("R10", "irq disabled", irq, 0);
      @(negedge clk); cfg_err_ie = 1'b1;
      #1 check("R10", "irq enabled", irq, 1);
      clear_write(8'h01);
      check("R9", "wrong bit keeps flag", ovr_flag, 1);
      clear_write(8'h04);
      check("R9", "clear", ovr_flag, 0);
      check("R10", "irq after clear", irq, 0);
   endtask

   task automatic t_rx_read();
      host_read();
      check("R4", "rx_full cleared", host_rx_full, 0);
      check("R4", "rx_data shown", host_rx_data, 8'hA5);
      rx_push(8'h77, 1'b0);
      check("R4", "ack after read", sh_rx_nack, 0);
   endtask

   task automatic t_rx_same_cycle();
      rx_push(8'h12, 1'b1);
      check("R11", "read+rx ack", sh_rx_nack, 0);
      check("R11", "read+rx data", host_rx_data, 8'h12);
      check("R11", "read+rx full", host_rx_full, 1);
      check("R11", "read+rx no flag", ovr_flag, 0);
      host_read();
   endtask

   task automatic t_tx_basic();
      host_write(8'h5A);
      check("R5", "tx_full set", host_tx_full, 1);
      tx_request();
      check("R5", "tx_byte", sh_tx_byte, 8'h5A);
      check("R5", "tx_full clear", host_tx_full, 0);
      check("R5", "no flag", ovr_flag, 0);
   endtask

   task automatic t_tx_underrun();
      tx_request();
      check("R6", "fill byte", sh_tx_byte, FILL);
      check("R6", "flag", ovr_flag, 1);
      clear_write(8'h04);
   endtask

   task automatic t_tx_after_stop();
      stop_strobe();
      host_write(8'hC3);
      tx_request();
      check("R7", "held after stop", sh_tx_byte, 8'hC3);
      check("R7", "flag full case", ovr_flag, 1);
      clear_write(8'h04);
      stop_strobe();
      tx_request();
      check("R7", "fill after stop", sh_tx_byte, FILL);
      check("R7", "flag empty case", ovr_flag, 1);
      clear_write(8'h04);
      host_write(8'h11);
      tx_request();
      check("R7", "later byte", sh_tx_byte, 8'h11);
      check("R7", "later no flag", ovr_flag, 0);
   endtask

   task automatic t_unchecked();
      @(negedge clk); cfg_nostretch = 1'b0;
      rx_push(8'h21, 1'b0);
      rx_push(8'h22, 1'b0);
      check("R8", "overwrite ack", sh_rx_nack, 0);
      check("R8", "overwrite data", host_rx_data, 8'h22);
      tx_request();
      check("R8", "fill unchecked", sh_tx_byte, FILL);
      check("R8", "no flag stretch", ovr_flag, 0);
      @(negedge clk); cfg_nostretch = 1'b1; cfg_slave = 1'b0;
      rx_push(8'h23, 1'b0);
      tx_request();
      check("R8", "no flag master", ovr_flag, 0);
      check("R8", "master overwrite", host_rx_data, 8'h23);
      @(negedge clk); cfg_slave = 1'b1;
      host_read();
   endtask

   task automatic t_tx_same_cycle();
      @(negedge clk); host_tx_wr = 1'b1; host_tx_wdata = 8'h99; sh_tx_req = 1'b1;
      @(negedge clk); host_tx_wr = 1'b0; sh_tx_req = 1'b0;
      check("R11", "write+req fill", sh_tx_byte, FILL);
      check("R11", "write+req flag", ovr_flag, 1);
      check("R11", "write+req held", host_tx_full, 1);
      clear_write(8'h04);
      tx_request();
      check("R11", "held byte next", sh_tx_byte, 8'h99);
   endtask

   task automatic t_set_beats_clear();
      rx_push(8'h40, 1'b0);
      @(negedge clk);
      sh_rx_valid = 1'b1; sh_rx_byte = 8'h41; host_clr_wr = 1'b1; host_clr_wdata = 8'h04;
      @(negedge clk);
      sh_rx_valid = 1'b0; host_clr_wr = 1'b0; host_clr_wdata = '0;
      check("R9", "set wins over clear", ovr_flag, 1);
      check("R3", "drop kept", host_rx_data, 8'h40);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rx_basic();
      t_rx_overrun();
      t_rx_read();
      host_read();
      t_rx_same_cycle();
      t_tx_basic();
      t_tx_underrun();
      t_tx_after_stop();
      t_unchecked();
      t_tx_same_cycle();
      t_set_beats_clear();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R1..all: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule